// File: doc/BRIEF.md
# Firmware Hub Read Target

This block is the target end of a four-bit multiplexed firmware-hub bus, limited to read cycles. It watches an active-low frame strobe and an incoming nibble bus and decodes a cycle header: a start code, a device select nibble, a 28-bit address and a burst size code. When the header is addressed to it, it takes the bus through a turnaround. It then signals two wait-sync codes and one ready-sync code, streams the requested bytes one nibble at a time, and hands the bus back to the host.

Inside the chip the block has two synchronous read ports, each with one cycle of latency. One serves a byte memory array and the other serves a register space. One address bit chooses between them. The nibble output is split into a data vector and an output-enable, so the pad ring or a bus model forms the shared wire.

Top module: `fwh_read_target`

## Requirements
- R1: A cycle starts only on a rising clock edge where `frame_n` is 0 and `nib_in` is 4'b1101. The same nibble with `frame_n` at 1 starts nothing.
- R2: The nibble sampled on the edge after the start is compared with `strap_id`. On a mismatch the block never raises `nib_oe` for that cycle.
- R3: The next seven nibbles form the 28-bit address, most significant nibble first.
- R4: The next nibble is the size code. Code 0 means 1 byte, 1 means 2, 2 means 4, 4 means 16 and 7 means 128. Any other code leaves `nib_oe` low and the block waits for a new start.
- R5: For a burst of 2^k bytes, address bits k-1..0 are taken as zero. Bytes are fetched from the aligned base upward.
- R6: Address bit 22 at 1 selects the memory port, with `mem_rd_addr` taken from address bits 18..0, so bits 19-21 and 23-27 have no effect. Bit 22 at 0 selects the register port, with the full 28-bit address on `reg_rd_addr`.
- R7: The nibble after the size code is the host turnaround and is not checked. On the next cycle the block raises `nib_oe` and drives 4'b1111.
- R8: After the turnaround the block drives 4'b0101 for exactly two cycles, then 4'b0000 for one cycle.
- R9: Each byte takes two cycles: bits 3..0 first, then bits 7..4. Bytes follow in ascending address order.
- R10: After the last data nibble the block drives 4'b1111 for one cycle, then drops `nib_oe`. A new start may be sampled on the next edge after that.
- R11: `nib_oe` is low out of reset, while idle and during every host-driven header cycle.
- R12: Each byte is requested by a one-cycle pulse on exactly one of `mem_rd_en` or `reg_rd_en`, never both. The read data is used one cycle later, and two requests are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe |
| nib_in | input | 4 | Nibble bus as driven by the host |
| strap_id | input | 4 | Strapped device select value |
| nib_out | output | 4 | Nibble driven by the target, valid while nib_oe is high |
| nib_oe | output | 1 | Target output enable for the nibble bus |
| mem_rd_en | output | 1 | Memory read request pulse |
| mem_rd_addr | output | MEM_AW | Memory byte address |
| mem_rd_data | input | 8 | Memory read data, one cycle after the request |
| reg_rd_en | output | 1 | Register read request pulse |
| reg_rd_addr | output | ADDR_W | Register byte address |
| reg_rd_data | input | 8 | Register read data, one cycle after the request |

## Verification
Two pairs of functions share a cycle. In the first, the cycle in which the block drops `nib_oe` for the final turnaround is also the cycle in which the host may present the next start. In the second, each low-nibble cycle both captures the current byte and issues the request for the next one. The bench issues every header immediately after the previous cycle's release, so a start always lands on the release cycle. It also runs bursts of up to 128 bytes. A scoreboard holds the exact expected nibble stream, built from address-dependent memory and register models, so a lost start, a byte overwritten by the next request, or a misplaced request shows up as a wrong or missing nibble.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  localparam logic [3:0] START_CODE = 4'b1101;
  localparam logic [3:0] TAR_CODE   = 4'b1111;
  localparam logic [3:0] WSYNC_CODE = 4'b0101;
  localparam logic [3:0] RSYNC_CODE = 4'b0000;

  typedef enum logic [2:0] {
    RX_IDLE, RX_ID, RX_ADDR, RX_SIZE, RX_HTAR, RX_BUSY
  } rx_state_t;

  typedef enum logic [3:0] {
    TX_IDLE, TX_TAR, TX_WS1, TX_WS2, TX_RSYNC,
    TX_DLO, TX_DHI, TX_TEND, TX_REL
  } tx_state_t;

  // burst size codes accepted by the target; code value is log2 of byte count
  function automatic logic size_code_ok(input logic [3:0] code);
    return (code == 4'd0) || (code == 4'd1) || (code == 4'd2) ||
           (code == 4'd4) || (code == 4'd7);
  endfunction

endpackage

// File: rtl/fwh_rx_decode.sv
module fwh_rx_decode
  import fwh_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int SZ_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        nib_in,
  input  logic [3:0]        strap_id,
  input  logic              tx_done,
  output logic              go,
  output logic              hdr_phase,
  output logic [ADDR_W-1:0] base_addr,
  output logic [SZ_W-1:0]   size_log2
);

  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int CNT_W     = $clog2(ADDR_NIBS);

  rx_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             start_seen;

  assign start_seen = !frame_n && (nib_in == START_CODE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RX_IDLE: if (start_seen) st_d = RX_ID;
      RX_ID:   st_d = (nib_in == strap_id) ? RX_ADDR : RX_IDLE;
      RX_ADDR: if (cnt_q == CNT_W'(ADDR_NIBS - 1)) st_d = RX_SIZE;
      RX_SIZE: st_d = size_code_ok(nib_in) ? RX_HTAR : RX_IDLE;
      RX_HTAR: st_d = RX_BUSY;
      RX_BUSY: if (tx_done) st_d = start_seen ? RX_ID : RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= RX_IDLE;
      cnt_q     <= '0;
      base_addr <= '0;
      size_log2 <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == RX_ADDR) begin
        base_addr <= {base_addr[ADDR_W-5:0], nib_in};
        cnt_q     <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
      if (st_q == RX_SIZE) size_log2 <= nib_in[SZ_W-1:0];
    end
  end

  assign go        = (st_q == RX_HTAR);
  assign hdr_phase = (st_q == RX_ID) || (st_q == RX_ADDR) ||
                     (st_q == RX_SIZE) || (st_q == RX_HTAR);

endmodule

// File: rtl/fwh_tx_seq.sv
module fwh_tx_seq
  import fwh_pkg::*;
#(
  parameter int SZ_W  = 3,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [SZ_W-1:0]  size_log2,
  input  logic [7:0]       rd_byte,
  output logic [3:0]       nib_out,
  output logic             nib_oe,
  output logic             rd_req,
  output logic [IDX_W-1:0] rd_idx,
  output logic             done
);

  tx_state_t        st_q, st_d;
  logic [SZ_W-1:0]  size_q;
  logic [IDX_W-1:0] out_cnt_q, last_idx, next_cnt;
  logic [7:0]       hold_q;

  always_comb begin
    last_idx = IDX_W'((32'd1 << size_q) - 32'd1);
    next_cnt = (st_q == TX_RSYNC) ? '0 : out_cnt_q + 1'b1;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TX_IDLE:  if (go) st_d = TX_TAR;
      TX_TAR:   st_d = TX_WS1;
      TX_WS1:   st_d = TX_WS2;
      TX_WS2:   st_d = TX_RSYNC;
      TX_RSYNC: st_d = TX_DLO;
      TX_DLO:   st_d = TX_DHI;
      TX_DHI:   st_d = (out_cnt_q == last_idx) ? TX_TEND : TX_DLO;
      TX_TEND:  st_d = TX_REL;
      TX_REL:   st_d = TX_IDLE;
      default:  st_d = TX_IDLE;
    endcase
  end

  // outputs are registered: each edge loads the values of the state entered
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= TX_IDLE;
      size_q    <= '0;
      out_cnt_q <= '0;
      hold_q    <= '0;
      nib_out   <= TAR_CODE;
      nib_oe    <= 1'b0;
      rd_req    <= 1'b0;
      rd_idx    <= '0;
    end else begin
      st_q   <= st_d;
      rd_req <= 1'b0;
      if (go && st_q == TX_IDLE) size_q <= size_log2;
      unique case (st_d)
        TX_TAR, TX_TEND: begin
          nib_oe  <= 1'b1;
          nib_out <= TAR_CODE;
        end
        TX_WS1: begin
          nib_oe  <= 1'b1;
          nib_out <= WSYNC_CODE;
        end
        TX_WS2: begin
          nib_oe  <= 1'b1;
          nib_out <= WSYNC_CODE;
          rd_req  <= 1'b1;            // first byte fetched two cycles ahead
          rd_idx  <= '0;
        end
        TX_RSYNC: begin
          nib_oe  <= 1'b1;
          nib_out <= RSYNC_CODE;
        end
        TX_DLO: begin
          nib_oe    <= 1'b1;
          nib_out   <= rd_byte[3:0];
          hold_q    <= rd_byte;
          out_cnt_q <= next_cnt;
          if (next_cnt != last_idx) begin
            rd_req <= 1'b1;           // prefetch following byte
            rd_idx <= next_cnt + 1'b1;
          end
        end
        TX_DHI: begin
          nib_oe  <= 1'b1;
          nib_out <= hold_q[7:4];
        end
        default: begin
          nib_oe  <= 1'b0;
          nib_out <= TAR_CODE;
        end
      endcase
    end
  end

  assign done = (st_q == TX_REL);

endmodule

// File: rtl/fwh_addr_map.sv
module fwh_addr_map #(
  parameter int ADDR_W    = 28,
  parameter int MEM_AW    = 19,
  parameter int SPACE_BIT = 22,
  parameter int SZ_W      = 3,
  parameter int IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [SZ_W-1:0]   size_log2,
  input  logic [IDX_W-1:0]  idx,
  input  logic              req,
  output logic              is_mem,
  output logic              mem_en,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              reg_en,
  output logic [ADDR_W-1:0] reg_addr
);

  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] full_addr;

  always_comb begin
    low_mask  = ADDR_W'((32'd1 << size_log2) - 32'd1);
    full_addr = (base_addr & ~low_mask) | ADDR_W'(idx);
  end

  assign is_mem   = base_addr[SPACE_BIT];
  assign mem_en   = req && is_mem;
  assign reg_en   = req && !is_mem;
  assign mem_addr = full_addr[MEM_AW-1:0];
  assign reg_addr = full_addr;

endmodule

// File: rtl/fwh_read_target.sv
module fwh_read_target #(
  parameter int ADDR_W    = 28,
  parameter int MEM_AW    = 19,
  parameter int SPACE_BIT = 22,
  parameter int MAX_LOG2  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic [3:0]        nib_in,
  input  logic [3:0]        strap_id,
  output logic [3:0]        nib_out,
  output logic              nib_oe,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              reg_rd_en,
  output logic [ADDR_W-1:0] reg_rd_addr,
  input  logic [7:0]        reg_rd_data
);

  localparam int SZ_W  = $clog2(MAX_LOG2 + 1);
  localparam int IDX_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

  if ((ADDR_W % 4) != 0 || SPACE_BIT >= ADDR_W || MEM_AW > SPACE_BIT ||
      MAX_LOG2 >= MEM_AW) begin : g_bad_cfg
    $error("fwh_read_target: inconsistent parameters");
  end

  logic              go_w, hdr_w, done_w, req_w, is_mem_w;
  logic [ADDR_W-1:0] base_w;
  logic [SZ_W-1:0]   size_w;
  logic [IDX_W-1:0]  idx_w;
  logic [7:0]        rd_byte_w;

  fwh_rx_decode #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_rx (
    .clk(clk), .rst(rst), .frame_n(frame_n), .nib_in(nib_in),
    .strap_id(strap_id), .tx_done(done_w), .go(go_w), .hdr_phase(hdr_w),
    .base_addr(base_w), .size_log2(size_w)
  );

  fwh_tx_seq #(.SZ_W(SZ_W), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst), .go(go_w), .size_log2(size_w), .rd_byte(rd_byte_w),
    .nib_out(nib_out), .nib_oe(nib_oe), .rd_req(req_w), .rd_idx(idx_w),
    .done(done_w)
  );

  fwh_addr_map #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SPACE_BIT(SPACE_BIT),
                 .SZ_W(SZ_W), .IDX_W(IDX_W)) u_map (
    .base_addr(base_w), .size_log2(size_w), .idx(idx_w), .req(req_w),
    .is_mem(is_mem_w), .mem_en(mem_rd_en), .mem_addr(mem_rd_addr),
    .reg_en(reg_rd_en), .reg_addr(reg_rd_addr)
  );

  assign rd_byte_w = is_mem_w ? mem_rd_data : reg_rd_data;

endmodule

// File: rtl/fwh_read_target_chk.sv
module fwh_read_target_chk (
  input logic       clk,
  input logic       rst,
  input logic       nib_oe,
  input logic [3:0] nib_out,
  input logic       mem_rd_en,
  input logic       reg_rd_en,
  input logic       go,
  input logic       hdr_phase
);

  a_r7_takeover: assert property (@(posedge clk) disable iff (rst)
    go |=> (nib_oe && nib_out == 4'b1111));

  a_r8_sync_codes: assert property (@(posedge clk) disable iff (rst)
    $rose(nib_oe) |-> ##1 (nib_out == 4'b0101) ##1 (nib_out == 4'b0101)
                      ##1 (nib_out == 4'b0000));

  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    $fell(nib_oe) |-> ($past(nib_out) == 4'b1111));

  a_r11_header_quiet: assert property (@(posedge clk) disable iff (rst)
    hdr_phase |-> !nib_oe);

  a_r12_one_port: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && reg_rd_en));

  a_r12_req_gap: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en || reg_rd_en) |=> !(mem_rd_en || reg_rd_en));

endmodule

bind fwh_read_target fwh_read_target_chk u_chk (
  .clk(clk), .rst(rst), .nib_oe(nib_oe), .nib_out(nib_out),
  .mem_rd_en(mem_rd_en), .reg_rd_en(reg_rd_en), .go(go_w), .hdr_phase(hdr_w)
);

// File: tb/fwh_read_target_tb_top.sv
`timescale 1ns/1ps
module fwh_read_target_tb_top;

  localparam int ADDR_W = 28;
  localparam int MEM_AW = 19;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              frame_n = 1'b1;
  logic [3:0]        nib_in = 4'hF;
  logic [3:0]        strap_id = 4'h6;
  logic [3:0]        nib_out;
  logic              nib_oe, mem_rd_en, reg_rd_en;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [ADDR_W-1:0] reg_rd_addr;
  logic [7:0]        mem_rd_data = 8'h00;
  logic [7:0]        reg_rd_data = 8'h00;

  int n_chk = 0, n_fail = 0, stray = 0;
  bit done_flag = 0;
  logic [3:0] exp_nib[$];
  string      exp_tag[$];

  always #2.5 clk = ~clk;

  fwh_read_target dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .nib_in(nib_in), .strap_id(strap_id),
    .nib_out(nib_out), .nib_oe(nib_oe), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .reg_rd_en(reg_rd_en),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  function automatic logic [7:0] mem_f(input logic [MEM_AW-1:0] a);
    return a[7:0] ^ a[18:11] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] reg_f(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[27:20] ^ 8'hA5;
  endfunction

  // synchronous read models, one cycle latency
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_f(mem_rd_addr);
    if (reg_rd_en) reg_rd_data <= reg_f(reg_rd_addr);
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every driven nibble with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en || reg_rd_en)
        check(!(mem_rd_en && reg_rd_en), "R12 both read ports", {mem_rd_en, reg_rd_en}, 32'h2);
      if (nib_oe) begin
        if (exp_nib.size() == 0) begin
          stray++;
          check(1'b0, "R11 unexpected drive", nib_out, 32'hFFFF);
        end else begin
          logic [3:0] e;
          string t;
          e = exp_nib.pop_front();
          t = exp_tag.pop_front();
          check(nib_out == e, t, nib_out, e);
        end
      end
    end
  end

  task automatic push(input logic [3:0] v, input string t);
    exp_nib.push_back(v);
    exp_tag.push_back(t);
  endtask

  task automatic bus_cycle(input logic [3:0] id, input logic [27:0] addr,
                           input logic [3:0] sz, input logic frame_lvl,
                           input bit resp, input string tag);
    int n;
    int s0;
    n  = resp ? (1 << sz) : 0;
    s0 = stray;
    if (resp) begin
      logic [27:0] base;
      base = addr & ~28'(n - 1);
      push(4'hF, {"R7 turnaround ", tag});
      push(4'h5, {"R8 wait sync 1 ", tag});
      push(4'h5, {"R8 wait sync 2 ", tag});
      push(4'h0, {"R8 ready sync ", tag});
      for (int i = 0; i < n; i++) begin
        logic [27:0] a;
        logic [7:0]  b;
        a = base | 28'(i);
        b = a[22] ? mem_f(a[MEM_AW-1:0]) : reg_f(a);
        push(b[3:0], {"R9 R5 R6 low nibble ", tag});
        push(b[7:4], {"R9 R5 R6 high nibble ", tag});
      end
      push(4'hF, {"R10 end turnaround ", tag});
    end
    @(negedge clk); frame_n = frame_lvl; nib_in = 4'hD;
    @(negedge clk); frame_n = 1'b1; nib_in = id;
    for (int i = 6; i >= 0; i--) begin
      @(negedge clk); nib_in = addr[i*4 +: 4];
    end
    @(negedge clk); nib_in = sz;
    @(negedge clk); nib_in = 4'hF;
    repeat (resp ? 5 + 2 * n : 12) @(negedge clk);
    @(posedge clk); #1;
    check(exp_nib.size() == 0, {"R10 all nibbles seen ", tag}, exp_nib.size(), 0);
    check(!nib_oe, {"R10 released ", tag}, nib_oe, 0);
    if (!resp) check(stray == s0, {"no response ", tag}, stray - s0, 0);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!nib_oe, "R11 reset oe", nib_oe, 0);
    check(!mem_rd_en && !reg_rd_en, "R12 reset read enables", {mem_rd_en, reg_rd_en}, 0);
    rst = 1'b0;
    // R3 R6 single byte from memory
    bus_cycle(4'h6, 28'h0412345, 4'd0, 1'b0, 1, "R3 single mem");
    // R5 two and four bytes from unaligned addresses
    bus_cycle(4'h6, 28'h04ABCD7, 4'd1, 1'b0, 1, "R5 two bytes");
    bus_cycle(4'h6, 28'h0455553, 4'd2, 1'b0, 1, "R5 four bytes");
    // R6 register space, 16 bytes, high bits decoded
    bus_cycle(4'h6, 28'hA3B1C29, 4'd4, 1'b0, 1, "R6 reg sixteen");
    // R6 memory with ignored high bits set, 128-byte burst
    bus_cycle(4'h6, 28'hFFF9A5F, 4'd7, 1'b0, 1, "R6 mem ignored bits 128");
    // R2 mismatched select
    bus_cycle(4'h3, 28'h0400000, 4'd0, 1'b0, 0, "R2 id mismatch");
    // R4 unsupported size codes
    bus_cycle(4'h6, 28'h0400010, 4'd3, 1'b0, 0, "R4 size 3");
    bus_cycle(4'h6, 28'h0400010, 4'd8, 1'b0, 0, "R4 size 8");
    // R1 start nibble with frame high
    bus_cycle(4'h6, 28'h0400020, 4'd0, 1'b1, 0, "R1 frame high");
    // back-to-back after ignored cycles, then different strap
    bus_cycle(4'h6, 28'h0123456, 4'd1, 1'b0, 1, "R9 reg two");
    strap_id = 4'hA;
    bus_cycle(4'hA, 28'h047FFFC, 4'd2, 1'b0, 1, "R2 new strap");
    bus_cycle(4'h6, 28'h047FFFC, 4'd2, 1'b0, 0, "R2 old strap");
    finish_run();
  end

endmodule